// File: doc/BRIEF.md
# Cascaded Synchronous Up-Counter

This block is a 12-bit synchronous binary up-counter assembled from identical 4-bit counter slices joined in a carry chain. Every slice is clocked by the same global clock. Each slice takes a synchronous active-low clear, a synchronous active-low parallel load, and two count-enable inputs. The first enable qualifies counting only. The second enable qualifies counting and also gates the slice's carry flag.

In the chain, the master count enable drives the first enable of every slice. The carry of each slice drives the second enable of the slice above it. The lowest slice takes the master enable on both inputs. With this wiring a carry is high for exactly one enabled cycle, so an upper slice steps once per full turn of the slices below it.

The terminal carry of the top slice is available at the top level for further extension. Clear and load are plain control pins with no handshake. They reach every slice at once, and each slice loads its own nibble of the 12-bit load value.

Top module: `casc_counter`

## Requirements
- R1: When clear_n is low at a rising edge, the count becomes 0x000 after that edge, whatever load_n and count_en are.
- R2: When clear_n is high and load_n is low at a rising edge, the count takes load_val after that edge, whatever count_en is. Bits 3:0 go to the lowest slice, bits 7:4 to the middle slice and bits 11:8 to the top slice.
- R3: When clear_n and load_n are high and count_en is high at a rising edge, the count becomes (count + 1) mod 4096. This includes every carry across slice boundaries.
- R4: When clear_n and load_n are high and count_en is low at a rising edge, the count is unchanged.
- R5: term_carry is high exactly when count equals 0xFFF and count_en is high. It is combinational from those values.
- R6: When count is 0xFFF and count_en is high, the next rising edge without clear or load gives count 0x000.
- R7: A slice whose second enable input is high has a carry flag that stays high for at most one cycle at a time while counting. An upper slice never advances while any lower slice is below 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock, rising edge |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| count_en | input | 1 | Master count enable |
| load_val | input | 12 | Parallel load value |
| count | output | 12 | Current count |
| term_carry | output | 1 | Terminal carry: count is 0xFFF and count_en is high |

## Verification
Clear, load and counting can all be requested in the same cycle. The bench drives clear_n, load_n and count_en in mixed combinations, including all three active together. It then checks that the count follows the priority clear, then load, then count. The bench also loads values just below slice boundaries, such as 0x0EF, 0x0FF and 0xFFE. It then runs the counter with enable gaps and compares each edge against an arithmetic 12-bit model. Each cycle it also checks term_carry against the count and enable seen at the ports.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;
  localparam int unsigned SLICE_W = 4;
  localparam int unsigned N_SLICES = 3;
  localparam int unsigned TOTAL_W = SLICE_W * N_SLICES;
endpackage

// File: rtl/casc_slice.sv
module casc_slice #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] q_r;
  logic         started;

  always_ff @(posedge clk) begin
    if (!clear_n)          q_r <= '0;
    else if (!load_n)      q_r <= din;
    else if (en_p && en_t) q_r <= q_r + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!clear_n) started <= 1'b1;
  end

  assign q     = q_r;
  assign carry = (q_r == ALL_ONES) && en_t;

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!started)
    !clear_n |=> (q_r == '0));
  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!started)
    (clear_n && !load_n) |=> (q_r == $past(din)));
  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!started)
    (clear_n && load_n && !(en_p && en_t)) |=> $stable(q_r));
  // R7
  carry_pulse_chk: assert property (@(posedge clk) disable iff (!started)
    (carry && en_p && clear_n && load_n) |=> !carry);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_counter_pkg::*;
(
  input  logic               clk,
  input  logic               clear_n,
  input  logic               load_n,
  input  logic               count_en,
  input  logic [TOTAL_W-1:0] load_val,
  output logic [TOTAL_W-1:0] count,
  output logic               term_carry
);
  logic [N_SLICES:0] chain;
  logic              started;

  assign chain[0] = count_en;

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    casc_slice #(.W(SLICE_W)) slice_i (
      .clk     (clk),
      .clear_n (clear_n),
      .load_n  (load_n),
      .en_p    (count_en),
      .en_t    (chain[s]),
      .din     (load_val[s*SLICE_W +: SLICE_W]),
      .q       (count[s*SLICE_W +: SLICE_W]),
      .carry   (chain[s+1])
    );
  end

  assign term_carry = chain[N_SLICES];

  always_ff @(posedge clk) begin
    if (!clear_n) started <= 1'b1;
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!started)
    (clear_n && load_n && count_en) |=> (count == $past(count) + 1'b1));
  // R5
  term_carry_chk: assert property (@(posedge clk) disable iff (!started)
    term_carry == (count_en && (&count)));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!started)
    (clear_n && load_n && count_en && (&count)) |=> (count == '0));
  // R7
  upper_hold_chk: assert property (@(posedge clk) disable iff (!started)
    (clear_n && load_n && count[SLICE_W-1:0] != '1) |=> $stable(count[TOTAL_W-1:SLICE_W]));
endmodule

// File: tb/casc_counter_tb_top.sv
module casc_counter_tb_top;
  logic        clk = 0;
  logic        clear_n = 1, load_n = 1, count_en = 0;
  logic [11:0] load_val = '0;
  logic [11:0] count;
  logic        term_carry;
  logic [11:0] model = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  casc_counter dut_i (.clk(clk), .clear_n(clear_n), .load_n(load_n),
    .count_en(count_en), .load_val(load_val), .count(count),
    .term_carry(term_carry));

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic step(bit c, bit l, bit e, logic [11:0] v, string req);
    clear_n = c; load_n = l; count_en = e; load_val = v;
    #1;
    chk("R5", {11'd0, term_carry}, {11'd0, e && (model == 12'hFFF)});
    if (!c) model = 12'h000;
    else if (!l) model = v;
    else if (e) model = model + 12'd1;
    @(posedge clk); #1;
    chk(req, count, model);
  endtask

  initial begin
    @(negedge clk);
    step(0, 1, 0, 12'h000, "R1");
    chk("R1", count, 12'h000);
    step(1, 1, 0, 12'h000, "R4");
    step(0, 0, 1, 12'h5A5, "R1");
    step(1, 0, 1, 12'h0EF, "R2");
    for (int i = 0; i < 40; i++) step(1, 1, (i % 3) != 1, 12'h000, "R3");
    step(1, 0, 0, 12'h0FF, "R2");
    step(1, 1, 0, 12'h000, "R4");
    step(1, 1, 1, 12'h000, "R3");
    step(1, 0, 1, 12'hFF0, "R7");
    for (int i = 0; i < 20; i++) step(1, 1, 1, 12'h000, "R7");
    step(1, 0, 1, 12'hFFE, "R2");
    step(1, 1, 1, 12'h000, "R3");
    step(1, 1, 0, 12'h000, "R4");
    step(1, 1, 1, 12'h000, "R6");
    chk("R6", count, 12'h000);
    for (int i = 0; i < 4200; i++) step(1, 1, (i % 11) != 5, 12'h000, "R3");
    for (int i = 0; i < 4096; i++) step(1, 1, 1, 12'h000, "R6");
    step(0, 0, 1, 12'h123, "R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule